// File: doc/BRIEF.md
# Reset-Time Strap Capture and Shared Pin Driver

This block reads board-level configuration from a group of shared pins while the chip is held in reset, then turns the same pins into outputs. Four LED pins and one general-purpose output pin together give a 5-bit management address. A separate mode pin chooses one of two roles: the chip drives an active-low interrupt request on it, or it stays an input that carries a fifth transmit bit into the chip.

Each LED pin also remembers the level it was strapped to. That level sets the LED drive polarity. A pin held high during reset drives its LED active low, and a pin pulled low drives its LED active high. The LED is therefore wired against the strap and does not disturb the strap reading. All pins are plain control signals, so there is no valid/ready handshake and no back-pressure. A new reading is taken only when reset is asserted again.

Top module: `boot_strap_mux`

## Requirements
- R1: While `rst_n` is low, every clock edge samples the pins. The latched straps are the pin levels seen at the last rising clock edge before `rst_n` goes high.
- R2: `mgmt_addr_o[3:0]` holds the strap of `led_pin_i[3:0]` and `mgmt_addr_o[4]` holds the strap of `gpo_pin_i`. With every pin high, the address is 5'b11111.
- R3: While `rst_n` is low, `led_pin_oe`, `gpo_pin_oe` and `mode_pin_oe` are all 0.
- R4: Output enables stay 0 until the first rising clock edge at which `rst_n` is high, and are 1 after it. Before that edge each LED pin shows its inactive level, which equals its strap value.
- R5: An LED pin strapped 1 is active low: `led_req_i`=1 drives 0 and `led_req_i`=0 drives 1.
- R6: An LED pin strapped 0 is active high: `led_req_i`=1 drives 1 and `led_req_i`=0 drives 0.
- R7: A mode strap of 1 gives `mode_irq_o`=1. After reset, `mode_pin_oe`=1, `mode_pin_o` = NOT `irq_i`, and `tx_ext_o`=0.
- R8: A mode strap of 0 gives `mode_irq_o`=0. After reset, `mode_pin_oe`=0 and `tx_ext_o` follows `mode_pin_i`.
- R9: After release, `mgmt_addr_o` and `mode_irq_o` do not change, whatever the pins do, until `rst_n` is asserted again.
- R10: After reset, `gpo_pin_o` follows `gpo_val_i` and `gpo_pin_oe` is 1.

Before the first clock edge of reset, the pin outputs and enables are not yet defined. R3 and R4 apply from the first clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Internal reset, active low; straps are taken at its release |
| led_pin_i | input | 4 | Levels read from the LED pins |
| led_pin_o | output | 4 | LED pin drive values |
| led_pin_oe | output | 4 | LED pin output enables |
| led_req_i | input | 4 | LED activity requests, 1 = lit |
| gpo_pin_i | input | 1 | Level read from the general-purpose pin |
| gpo_pin_o | output | 1 | General-purpose pin drive value |
| gpo_pin_oe | output | 1 | General-purpose pin output enable |
| gpo_val_i | input | 1 | Value to drive on the general-purpose pin after reset |
| mode_pin_i | input | 1 | Level read from the mode pin |
| mode_pin_o | output | 1 | Mode pin drive value (interrupt, active low) |
| mode_pin_oe | output | 1 | Mode pin output enable |
| irq_i | input | 1 | Internal interrupt request, active high |
| tx_ext_o | output | 1 | Extra transmit bit taken from the mode pin |
| mgmt_addr_o | output | 5 | Latched management address |
| mode_irq_o | output | 1 | Latched mode, 1 = interrupt output |

## Verification
The bench runs a table of strap patterns through the reset sequence. The patterns are all-high, all-low, alternating LED patterns, a single low bit at each end, and both mode values. They show whether the address bits are mapped to the right pins, and whether the LED polarity follows each pin's own strap rather than a shared or swapped one. For every pattern, all sixteen LED request combinations are driven, so an inverted or crossed LED lane is caught. Directed tests move the pins after release to show that the latched values hold, check the window between release and the first clock, and drive the mode pin in both roles.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic {
    MODE_TXEXT = 1'b0,
    MODE_IRQ   = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/strap_capture.sv
// Tracks pin levels during reset; the last sample before release is kept.
module strap_capture #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] straps_o,
  output logic         armed_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      straps_o <= pins_i;
      armed_o  <= 1'b0;
    end else begin
      armed_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/led_drive.sv
// Per-lane LED driver; polarity taken from the lane's own strap.
module led_drive #(
  parameter int N = 4
) (
  input  logic         armed_i,
  input  logic [N-1:0] strap_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pin_o,
  output logic [N-1:0] pin_oe
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    // strap 1 -> active low, strap 0 -> active high; inactive level == strap
    always_comb begin
      pin_oe[g] = armed_i;
      pin_o[g]  = armed_i ? (req_i[g] ^ strap_i[g]) : strap_i[g];
    end
  end
endmodule

// File: rtl/mode_pin_mux.sv
module mode_pin_mux
  import strap_pkg::*;
(
  input  logic      armed_i,
  input  pin_mode_e mode_i,
  input  logic      irq_i,
  input  logic      pin_i,
  output logic      pin_o,
  output logic      pin_oe,
  output logic      tx_ext_o
);
  always_comb begin
    pin_o    = 1'b1;
    pin_oe   = 1'b0;
    tx_ext_o = 1'b0;
    if (armed_i) begin
      if (mode_i == MODE_IRQ) begin
        pin_oe = 1'b1;
        pin_o  = ~irq_i;
      end else begin
        tx_ext_o = pin_i;
      end
    end
  end
endmodule

// File: rtl/boot_strap_mux.sv
module boot_strap_mux
  import strap_pkg::*;
#(
  parameter int NUM_LED = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LED-1:0] led_pin_i,
  output logic [NUM_LED-1:0] led_pin_o,
  output logic [NUM_LED-1:0] led_pin_oe,
  input  logic [NUM_LED-1:0] led_req_i,
  input  logic               gpo_pin_i,
  output logic               gpo_pin_o,
  output logic               gpo_pin_oe,
  input  logic               gpo_val_i,
  input  logic               mode_pin_i,
  output logic               mode_pin_o,
  output logic               mode_pin_oe,
  input  logic               irq_i,
  output logic               tx_ext_o,
  output logic [NUM_LED:0]   mgmt_addr_o,
  output logic               mode_irq_o
);
  localparam int ADDR_W  = NUM_LED + 1;
  localparam int STRAP_W = ADDR_W + 1;

  logic [STRAP_W-1:0] straps;
  logic               armed;
  pin_mode_e          mode;

  strap_capture #(.W(STRAP_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_i   ({mode_pin_i, gpo_pin_i, led_pin_i}),
    .straps_o (straps),
    .armed_o  (armed)
  );

  assign mgmt_addr_o = straps[ADDR_W-1:0];
  assign mode        = pin_mode_e'(straps[STRAP_W-1]);
  assign mode_irq_o  = (mode == MODE_IRQ);

  led_drive #(.N(NUM_LED)) u_led (
    .armed_i (armed),
    .strap_i (straps[NUM_LED-1:0]),
    .req_i   (led_req_i),
    .pin_o   (led_pin_o),
    .pin_oe  (led_pin_oe)
  );

  assign gpo_pin_oe = armed;
  assign gpo_pin_o  = armed ? gpo_val_i : straps[NUM_LED];

  mode_pin_mux u_mode (
    .armed_i  (armed),
    .mode_i   (mode),
    .irq_i    (irq_i),
    .pin_i    (mode_pin_i),
    .pin_o    (mode_pin_o),
    .pin_oe   (mode_pin_oe),
    .tx_ext_o (tx_ext_o)
  );
endmodule

// File: rtl/strap_checker.sv
module strap_checker #(
  parameter int NUM_LED = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_LED-1:0] led_pin_o,
  input logic [NUM_LED-1:0] led_pin_oe,
  input logic [NUM_LED-1:0] led_req_i,
  input logic               gpo_pin_oe,
  input logic               mode_pin_i,
  input logic               mode_pin_o,
  input logic               mode_pin_oe,
  input logic               irq_i,
  input logic               tx_ext_o,
  input logic [NUM_LED:0]   mgmt_addr_o,
  input logic               mode_irq_o
);
  // Evaluated only while reset is held; a release cancels the attempt.
  p_tristate_in_reset_r3: assert property (@(posedge clk) disable iff (rst_n)
    !rst_n |=> (led_pin_oe == '0 && !gpo_pin_oe && !mode_pin_oe));

  p_enable_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (&led_pin_oe && gpo_pin_oe));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(mgmt_addr_o) && $stable(mode_irq_o)));

  for (genvar g = 0; g < NUM_LED; g++) begin : g_pol
    // R5 / R6: a lit LED never shows its strap level
    p_led_lit_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (led_pin_oe[g] && led_req_i[g]) |-> (led_pin_o[g] != mgmt_addr_o[g]));
  end

  p_irq_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_irq_o && mode_pin_oe) |-> (mode_pin_o == !irq_i && !tx_ext_o));

  p_txext_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_irq_o |-> (!mode_pin_oe && (tx_ext_o == (mode_pin_i && gpo_pin_oe))));
endmodule

bind boot_strap_mux strap_checker #(.NUM_LED(NUM_LED)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .led_pin_o   (led_pin_o),
  .led_pin_oe  (led_pin_oe),
  .led_req_i   (led_req_i),
  .gpo_pin_oe  (gpo_pin_oe),
  .mode_pin_i  (mode_pin_i),
  .mode_pin_o  (mode_pin_o),
  .mode_pin_oe (mode_pin_oe),
  .irq_i       (irq_i),
  .tx_ext_o    (tx_ext_o),
  .mgmt_addr_o (mgmt_addr_o),
  .mode_irq_o  (mode_irq_o)
);

// File: tb/test_boot_strap_mux.sv
`timescale 1ns/1ps
module test_boot_strap_mux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] led_pin_i = 4'hF, led_req_i = 4'h0;
  logic [3:0] led_pin_o, led_pin_oe;
  logic       gpo_pin_i = 1'b1, gpo_val_i = 1'b0, mode_pin_i = 1'b1, irq_i = 1'b0;
  logic       gpo_pin_o, gpo_pin_oe, mode_pin_o, mode_pin_oe, tx_ext_o, mode_irq_o;
  logic [4:0] mgmt_addr_o;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  boot_strap_mux i_boot_strap_mux (
    .clk(clk), .rst_n(rst_n),
    .led_pin_i(led_pin_i), .led_pin_o(led_pin_o), .led_pin_oe(led_pin_oe), .led_req_i(led_req_i),
    .gpo_pin_i(gpo_pin_i), .gpo_pin_o(gpo_pin_o), .gpo_pin_oe(gpo_pin_oe), .gpo_val_i(gpo_val_i),
    .mode_pin_i(mode_pin_i), .mode_pin_o(mode_pin_o), .mode_pin_oe(mode_pin_oe),
    .irq_i(irq_i), .tx_ext_o(tx_ext_o), .mgmt_addr_o(mgmt_addr_o), .mode_irq_o(mode_irq_o)
  );

  // {led straps[3:0], gpo strap, mode strap}
  localparam logic [5:0] VEC [0:7] = '{
    6'b1111_1_1, 6'b0000_0_0, 6'b1010_1_0, 6'b0101_0_1,
    6'b1110_1_1, 6'b0111_1_0, 6'b1111_0_1, 6'b0001_1_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Hold reset with the given straps, check tristate, release at a falling edge.
  task automatic do_reset(input logic [5:0] v);
    @(negedge clk);
    rst_n = 1'b0;
    led_pin_i = v[5:2]; gpo_pin_i = v[1]; mode_pin_i = v[0];
    repeat (3) @(negedge clk);
    chk("R3 oe in reset", {led_pin_oe, gpo_pin_oe, mode_pin_oe}, 6'd0);
    rst_n = 1'b1;
    #1;
    chk("R4 oe before first edge", {led_pin_oe, gpo_pin_oe}, 5'd0);
    chk("R4 led inactive level", led_pin_o, v[5:2]);
    @(negedge clk);
    chk("R4 oe after first edge", {led_pin_oe, gpo_pin_oe}, 5'h1F);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // Table walk
    for (int k = 0; k < 8; k++) begin
      do_reset(VEC[k]);
      chk("R1 R2 address", mgmt_addr_o, {VEC[k][1], VEC[k][5:2]});
      chk("R7 R8 mode", mode_irq_o, VEC[k][0]);
      for (int r = 0; r < 16; r++) begin
        led_req_i = r[3:0];
        #1;
        // strap 1 -> active low (R5), strap 0 -> active high (R6)
        chk("R5 R6 led drive", led_pin_o, r[3:0] ^ VEC[k][5:2]);
      end
      led_req_i = 4'h0;
      // R9: move pins, latched values hold
      led_pin_i = ~VEC[k][5:2]; gpo_pin_i = ~VEC[k][1];
      repeat (2) @(negedge clk);
      chk("R9 addr held", mgmt_addr_o, {VEC[k][1], VEC[k][5:2]});
      chk("R9 mode held", mode_irq_o, VEC[k][0]);
    end

    // R2 default all-high
    do_reset(6'b111111);
    chk("R2 default addr", mgmt_addr_o, 5'b11111);

    // R7 interrupt mode
    irq_i = 1'b0; #1;
    chk("R7 irq idle", {mode_pin_oe, mode_pin_o, tx_ext_o}, 3'b110);
    irq_i = 1'b1; #1;
    chk("R7 irq active", {mode_pin_oe, mode_pin_o, tx_ext_o}, 3'b100);
    mode_pin_i = 1'b0; #1;
    chk("R9 R7 mode pin ignored", {mode_irq_o, tx_ext_o}, 2'b10);
    irq_i = 1'b0;

    // R10 general-purpose output
    gpo_val_i = 1'b1; #1;
    chk("R10 gpo high", {gpo_pin_oe, gpo_pin_o}, 2'b11);
    gpo_val_i = 1'b0; #1;
    chk("R10 gpo low", {gpo_pin_oe, gpo_pin_o}, 2'b10);

    // R8 transmit-bit mode
    do_reset(6'b111110);
    mode_pin_i = 1'b1; #1;
    chk("R8 tx bit high", {mode_pin_oe, tx_ext_o}, 2'b01);
    mode_pin_i = 1'b0; #1;
    chk("R8 tx bit low", {mode_pin_oe, tx_ext_o}, 2'b00);
    irq_i = 1'b1; #1;
    chk("R8 irq ignored", {mode_pin_oe, tx_ext_o}, 2'b00);
    irq_i = 1'b0;

    // R1: a change after the last edge in reset is not captured
    @(negedge clk);
    rst_n = 1'b0;
    led_pin_i = 4'h3; gpo_pin_i = 1'b0; mode_pin_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    led_pin_i = 4'hC; gpo_pin_i = 1'b1;
    @(negedge clk);
    chk("R1 last sample kept", mgmt_addr_o, 5'b00011);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule